// File: doc/BRIEF.md
# Trigger Timestamp Match Filter

This block sits in a pixel-sensor readout chain, between the per-column hit stores and the bank of output FIFOs. A double column tags each hit address with the current bunch timestamp as the hit leaves the column. The block supplies that timestamp from a free-running counter, takes the tagged hits on a valid/ready input, and forwards or discards each one. The output bank consists of four FIFOs, each 256 entries deep.

In trigger mode, a registered trigger carries a timestamp. A hit is forwarded only when its tag falls inside an inclusive window centred on the trigger timestamp minus a programmable latency, with a programmable half-width, and the comparison is taken modulo the counter width. Every other hit is consumed and dropped. In triggerless mode, every hit is forwarded, which is the setting used for chip testing. Forwarded entries are dealt round-robin to the output FIFOs. A full FIFO stalls the input and no hit is lost.

Top module: `ts_match_filter`

## Requirements
- R1: After reset, `out_valid_o` is all zero, `ts_now_o` is 0, `trig_ovf_o` is 0 and `hit_ready_o` is 1.
- R2: `ts_now_o` increases by one on the clock edge of each cycle in which `bunch_en_i` is 1, and it wraps from 255 to 0. In all other cycles it holds its value.
- R3: In triggerless mode (active mode value 0), every accepted hit leaves the block once, in arrival order, with its address and timestamp unchanged.
- R4: In trigger mode (active mode value 1), a hit is forwarded only if a trigger is pending and the hit timestamp lies within `win_i` of (trigger timestamp − `latency_i`) mod 256, measured in either direction modulo 256. Both window edges are included.
- R5: In trigger mode, a hit that does not match, or that arrives while no trigger is pending, is still accepted (`hit_ready_o` stays high) and never appears on the output.
- R6: A trigger presented with `trig_valid_i` can be matched from the following cycle onward. It stays pending up to and including the cycle of the TRIG_HOLD-th (default 4) `bunch_en_i` cycle after it was loaded, and it is retired after that cycle.
- R7: A trigger that arrives while another is pending, and is not retiring in that cycle, is discarded. The pending trigger is kept, and `trig_ovf_o` is 1 for exactly the next cycle.
- R8: A trigger that arrives in the same cycle as the retirement of the pending trigger replaces it, and `trig_ovf_o` stays 0.
- R9: At most one bit of `out_valid_o` is set. Successive forwarded entries go to FIFO 0, 1, 2, 3, 0, … across the whole run.
- R10: While the selected FIFO's `out_ready_i` bit is 0, the pending output entry and its valid stay unchanged and `hit_ready_o` is 0. No hit is lost.
- R11: A change on `trig_mode_i` takes effect only in a cycle after the output register is empty. A hit accepted while an entry is still held is filtered under the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trig_mode_i | input | 1 | Requested mode: 1 trigger, 0 triggerless |
| latency_i | input | TS_W | Trigger latency in bunch ticks |
| win_i | input | TS_W | Match window half-width, inclusive |
| bunch_en_i | input | 1 | Bunch-clock enable for the timestamp counter |
| ts_now_o | output | TS_W | Current timestamp for column tagging |
| hit_valid_i | input | 1 | Hit offered |
| hit_ready_o | output | 1 | Hit taken on this edge when valid |
| hit_addr_i | input | ADDR_W | Hit pixel address |
| hit_ts_i | input | TS_W | Hit timestamp tag |
| trig_valid_i | input | 1 | Trigger strobe |
| trig_ts_i | input | TS_W | Trigger timestamp |
| trig_ovf_o | output | 1 | One-cycle pulse when a trigger is discarded |
| out_valid_o | output | NUM_OUT | One-hot write strobe toward the output FIFOs |
| out_ready_i | input | NUM_OUT | Per-FIFO not-full indication |
| out_addr_o | output | ADDR_W | Forwarded address |
| out_ts_o | output | TS_W | Forwarded timestamp |

## Verification
A new trigger strobe can land in the same cycle in which the pending trigger reaches its last bunch tick and retires. The bench builds this case by loading a trigger and applying three bunch ticks, then asserting the fourth tick and a fresh trigger together. It judges the result by the absence of any overflow pulse, by a hit matching the new window being forwarded, and by a hit that matches only the old window being dropped. A second collision happens when the output register drains in the same edge that takes a hit while the mode input has changed. The bench judges that case by the stalled-in hit still passing under the old mode, and by a later hit being filtered once the register has emptied.

// File: rtl/ts_filt_pkg.sv
package ts_filt_pkg;
    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_TRIG = 1'b1
    } filt_mode_e;
endpackage

// File: rtl/ts_filt_tsgen.sv
module ts_filt_tsgen #(
    parameter int TS_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    output logic [TS_W-1:0] ts_o
);
    logic [TS_W-1:0] ts_d, ts_q;

    always_comb begin
        ts_d = ts_q;
        if (tick_i) ts_d = ts_q + TS_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ts_q <= '0;
        else         ts_q <= ts_d;
    end

    assign ts_o = ts_q;
endmodule

// File: rtl/ts_filt_trig.sv
module ts_filt_trig #(
    parameter int TS_W      = 8,
    parameter int TRIG_HOLD = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic            trig_valid_i,
    input  logic [TS_W-1:0] trig_ts_i,
    output logic            pend_vld_o,
    output logic [TS_W-1:0] pend_ts_o,
    output logic            ovf_o
);
    localparam int HOLD_W = $clog2(TRIG_HOLD + 1);

    typedef struct packed {
        logic              vld;
        logic [TS_W-1:0]   ts;
        logic [HOLD_W-1:0] cnt;
        logic              ovf;
    } trig_st_t;

    trig_st_t st_d, st_q;
    logic     retire;

    always_comb begin
        st_d   = st_q;
        retire = st_q.vld && tick_i && (st_q.cnt == HOLD_W'(TRIG_HOLD - 1));
        st_d.ovf = trig_valid_i && st_q.vld && !retire;
        if (trig_valid_i && (!st_q.vld || retire)) begin
            st_d.vld = 1'b1;
            st_d.ts  = trig_ts_i;
            st_d.cnt = '0;
        end else if (retire) begin
            st_d.vld = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.vld && tick_i) begin
            st_d.cnt = st_q.cnt + HOLD_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_vld_o = st_q.vld;
    assign pend_ts_o  = st_q.ts;
    assign ovf_o      = st_q.ovf;
endmodule

// File: rtl/ts_filt_window.sv
module ts_filt_window #(
    parameter int TS_W = 8
) (
    input  logic            pend_vld_i,
    input  logic [TS_W-1:0] pend_ts_i,
    input  logic [TS_W-1:0] latency_i,
    input  logic [TS_W-1:0] win_i,
    input  logic [TS_W-1:0] hit_ts_i,
    output logic            match_o
);
    logic [TS_W-1:0] centre, fwd, bwd;

    always_comb begin
        centre  = pend_ts_i - latency_i;
        fwd     = hit_ts_i - centre;
        bwd     = centre - hit_ts_i;
        match_o = pend_vld_i && ((fwd <= win_i) || (bwd <= win_i));
    end
endmodule

// File: rtl/ts_match_filter.sv
module ts_match_filter
    import ts_filt_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int TS_W      = 8,
    parameter int NUM_OUT   = 4,
    parameter int TRIG_HOLD = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               trig_mode_i,
    input  logic [TS_W-1:0]    latency_i,
    input  logic [TS_W-1:0]    win_i,
    input  logic               bunch_en_i,
    output logic [TS_W-1:0]    ts_now_o,
    input  logic               hit_valid_i,
    output logic               hit_ready_o,
    input  logic [ADDR_W-1:0]  hit_addr_i,
    input  logic [TS_W-1:0]    hit_ts_i,
    input  logic               trig_valid_i,
    input  logic [TS_W-1:0]    trig_ts_i,
    output logic               trig_ovf_o,
    output logic [NUM_OUT-1:0] out_valid_o,
    input  logic [NUM_OUT-1:0] out_ready_i,
    output logic [ADDR_W-1:0]  out_addr_o,
    output logic [TS_W-1:0]    out_ts_o
);
    localparam int PTR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [TS_W-1:0]   ts;
        logic [PTR_W-1:0]  ptr;
        filt_mode_e        mode;
    } out_st_t;

    out_st_t         st_d, st_q;
    logic            pend_vld;
    logic [TS_W-1:0] pend_ts;
    logic            match;
    logic            fire, accept, pass;

    ts_filt_tsgen #(.TS_W(TS_W)) u_tsgen (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (bunch_en_i),
        .ts_o   (ts_now_o)
    );

    ts_filt_trig #(.TS_W(TS_W), .TRIG_HOLD(TRIG_HOLD)) u_trig (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (bunch_en_i),
        .trig_valid_i (trig_valid_i),
        .trig_ts_i    (trig_ts_i),
        .pend_vld_o   (pend_vld),
        .pend_ts_o    (pend_ts),
        .ovf_o        (trig_ovf_o)
    );

    ts_filt_window #(.TS_W(TS_W)) u_window (
        .pend_vld_i (pend_vld),
        .pend_ts_i  (pend_ts),
        .latency_i  (latency_i),
        .win_i      (win_i),
        .hit_ts_i   (hit_ts_i),
        .match_o    (match)
    );

    always_comb begin
        st_d        = st_q;
        fire        = st_q.vld && out_ready_i[st_q.ptr];
        hit_ready_o = !st_q.vld || fire;
        accept      = hit_valid_i && hit_ready_o;
        pass        = (st_q.mode == MODE_FREE) || match;

        if (fire) begin
            st_d.vld = 1'b0;
            st_d.ptr = (st_q.ptr == PTR_W'(NUM_OUT - 1)) ? '0 : st_q.ptr + PTR_W'(1);
        end
        if (accept && pass) begin
            st_d.vld  = 1'b1;
            st_d.addr = hit_addr_i;
            st_d.ts   = hit_ts_i;
        end
        if (!st_q.vld) st_d.mode = filt_mode_e'(trig_mode_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{vld: 1'b0, addr: '0, ts: '0, ptr: '0, mode: MODE_FREE};
        else         st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_strobe
        assign out_valid_o[g] = st_q.vld && (st_q.ptr == PTR_W'(g));
    end

    assign out_addr_o = st_q.addr;
    assign out_ts_o   = st_q.ts;
endmodule

// File: rtl/ts_match_filter_chk.sv
module ts_match_filter_chk #(
    parameter int ADDR_W  = 10,
    parameter int TS_W    = 8,
    parameter int NUM_OUT = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               bunch_en_i,
    input logic [TS_W-1:0]    ts_now_o,
    input logic               hit_ready_o,
    input logic               trig_valid_i,
    input logic               trig_ovf_o,
    input logic [NUM_OUT-1:0] out_valid_o,
    input logic [NUM_OUT-1:0] out_ready_i,
    input logic [ADDR_W-1:0]  out_addr_o,
    input logic [TS_W-1:0]    out_ts_o
);
    logic stalled;
    assign stalled = (out_valid_o != '0) && ((out_valid_o & out_ready_i) == '0);

    assert_onehot_out_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(out_valid_o));

    assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stalled |=> $stable(out_valid_o) && $stable(out_addr_o) && $stable(out_ts_o));

    assert_stall_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stalled |-> !hit_ready_o);

    assert_ts_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bunch_en_i |=> ts_now_o == TS_W'($past(ts_now_o) + TS_W'(1)));

    assert_ts_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bunch_en_i |=> $stable(ts_now_o));

    assert_ovf_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(trig_ovf_o) |-> $past(trig_valid_i));
endmodule

bind ts_match_filter ts_match_filter_chk #(
    .ADDR_W(ADDR_W), .TS_W(TS_W), .NUM_OUT(NUM_OUT)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bunch_en_i   (bunch_en_i),
    .ts_now_o     (ts_now_o),
    .hit_ready_o  (hit_ready_o),
    .trig_valid_i (trig_valid_i),
    .trig_ovf_o   (trig_ovf_o),
    .out_valid_o  (out_valid_o),
    .out_ready_i  (out_ready_i),
    .out_addr_o   (out_addr_o),
    .out_ts_o     (out_ts_o)
);

// File: tb/ts_match_filter_bench.sv
module ts_match_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_mode = 1'b0;
    logic [7:0] latency = 8'd0;
    logic [7:0] win = 8'd0;
    logic       bunch_en = 1'b0;
    logic [7:0] ts_now;
    logic       hit_valid = 1'b0;
    logic       hit_ready;
    logic [9:0] hit_addr = '0;
    logic [7:0] hit_ts = '0;
    logic       trig_valid = 1'b0;
    logic [7:0] trig_ts = '0;
    logic       trig_ovf;
    logic [3:0] out_valid;
    logic [3:0] out_ready = 4'hF;
    logic [9:0] out_addr;
    logic [7:0] out_ts;

    int n_chk = 0;
    int n_fail = 0;
    int nrec = 0;
    int gidx = 0;
    logic [9:0] rec_addr [0:63];
    logic [7:0] rec_ts   [0:63];
    int         rec_fifo [0:63];
    int         rec_g    [0:63];

    always #5 clk = ~clk;

    ts_match_filter u_ts_match_filter (
        .clk_i(clk), .rst_ni(rst_n), .trig_mode_i(trig_mode), .latency_i(latency),
        .win_i(win), .bunch_en_i(bunch_en), .ts_now_o(ts_now),
        .hit_valid_i(hit_valid), .hit_ready_o(hit_ready), .hit_addr_i(hit_addr),
        .hit_ts_i(hit_ts), .trig_valid_i(trig_valid), .trig_ts_i(trig_ts),
        .trig_ovf_o(trig_ovf), .out_valid_o(out_valid), .out_ready_i(out_ready),
        .out_addr_o(out_addr), .out_ts_o(out_ts)
    );

    // Record every entry that will be written on the coming edge.
    always @(negedge clk) begin
        if (rst_n && ((out_valid & out_ready) != 4'h0)) begin
            if (nrec < 64) begin
                rec_addr[nrec] = out_addr;
                rec_ts[nrec]   = out_ts;
                rec_g[nrec]    = gidx;
                rec_fifo[nrec] = 0;
                for (int i = 0; i < 4; i++) if (out_valid[i]) rec_fifo[nrec] = i;
                nrec++;
            end
            gidx++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic send_hit(input int a, input int t);
        hit_valid = 1'b1; hit_addr = 10'(a); hit_ts = 8'(t);
        forever begin
            @(negedge clk);
            if (hit_ready) break;
        end
        @(posedge clk); #1;
        hit_valid = 1'b0;
    endtask

    task automatic send_trig(input int t);
        trig_valid = 1'b1; trig_ts = 8'(t);
        @(posedge clk); #1;
        trig_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bunch_en = 1'b1;
            @(posedge clk); #1;
            bunch_en = 1'b0;
        end
    endtask

    task automatic expect_addrs(input string req, input int exp_n, input int a0, input int a1,
                                input int a2, input int a3);
        int ea [4];
        ea = '{a0, a1, a2, a3};
        cyc(4);
        chk(nrec == exp_n, req, nrec, exp_n);
        for (int i = 0; i < exp_n && i < nrec; i++) begin
            chk(int'(rec_addr[i]) == ea[i], req, int'(rec_addr[i]), ea[i]);
            chk(rec_fifo[i] == rec_g[i] % 4, "R9", rec_fifo[i], rec_g[i] % 4);
        end
    endtask

    task automatic t_reset;
        chk(out_valid == 4'h0, "R1", int'(out_valid), 0);
        chk(ts_now == 8'd0, "R1", int'(ts_now), 0);
        chk(trig_ovf == 1'b0, "R1", int'(trig_ovf), 0);
        chk(hit_ready == 1'b1, "R1", int'(hit_ready), 1);
    endtask

    task automatic t_counter;
        ticks(5);
        chk(ts_now == 8'd5, "R2", int'(ts_now), 5);
        cyc(3);
        chk(ts_now == 8'd5, "R2", int'(ts_now), 5);
        ticks(295);
        chk(ts_now == 8'd44, "R2", int'(ts_now), 44);
    endtask

    task automatic t_triggerless;
        nrec = 0;
        trig_mode = 1'b0; cyc(2);
        for (int i = 0; i < 6; i++) send_hit(100 + i, (i * 37) & 255);
        cyc(4);
        chk(nrec == 6, "R3", nrec, 6);
        for (int i = 0; i < 6 && i < nrec; i++) begin
            chk(int'(rec_addr[i]) == 100 + i, "R3", int'(rec_addr[i]), 100 + i);
            chk(int'(rec_ts[i]) == ((i * 37) & 255), "R3", int'(rec_ts[i]), (i * 37) & 255);
            chk(rec_fifo[i] == rec_g[i] % 4, "R9", rec_fifo[i], rec_g[i] % 4);
        end
    endtask

    task automatic t_window;
        trig_mode = 1'b1; latency = 8'd10; win = 8'd3; cyc(2);
        nrec = 0;
        send_trig(50);
        send_hit(1, 37); send_hit(2, 36); send_hit(3, 43); send_hit(4, 44); send_hit(5, 40);
        expect_addrs("R4", 3, 1, 3, 5, 0);
        ticks(4);
        nrec = 0;
        win = 8'd6;
        send_trig(5);
        send_hit(6, 245); send_hit(7, 244); send_hit(8, 1); send_hit(9, 2);
        expect_addrs("R4", 2, 6, 8, 0, 0);
        ticks(4);
    endtask

    task automatic t_lifetime;
        nrec = 0;
        latency = 8'd0; win = 8'd0;
        send_hit(10, 90);
        trig_valid = 1'b1; trig_ts = 8'd90;
        hit_valid = 1'b1; hit_addr = 10'd11; hit_ts = 8'd90;
        @(posedge clk); #1;
        trig_valid = 1'b0; hit_valid = 1'b0;
        send_hit(12, 90);
        ticks(3);
        send_hit(13, 90);
        ticks(1);
        send_hit(14, 90);
        expect_addrs("R6", 2, 12, 13, 0, 0);
        chk(hit_ready == 1'b1, "R5", int'(hit_ready), 1);
    endtask

    task automatic t_overflow;
        nrec = 0;
        send_trig(100);
        send_trig(200);
        @(negedge clk);
        chk(trig_ovf == 1'b1, "R7", int'(trig_ovf), 1);
        @(negedge clk);
        chk(trig_ovf == 1'b0, "R7", int'(trig_ovf), 0);
        @(posedge clk); #1;
        send_hit(20, 200); send_hit(21, 100);
        expect_addrs("R7", 1, 21, 0, 0, 0);
        ticks(4);
    endtask

    task automatic t_retire_collision;
        nrec = 0;
        send_trig(60);
        ticks(3);
        bunch_en = 1'b1; trig_valid = 1'b1; trig_ts = 8'd70;
        @(posedge clk); #1;
        bunch_en = 1'b0; trig_valid = 1'b0;
        @(negedge clk);
        chk(trig_ovf == 1'b0, "R8", int'(trig_ovf), 0);
        @(posedge clk); #1;
        send_hit(30, 60); send_hit(31, 70);
        expect_addrs("R8", 1, 31, 0, 0, 0);
        ticks(4);
    endtask

    task automatic t_backpressure;
        trig_mode = 1'b0; cyc(2);
        nrec = 0;
        out_ready = 4'h0;
        send_hit(40, 1);
        hit_valid = 1'b1; hit_addr = 10'd41; hit_ts = 8'd2;
        cyc(1);
        @(negedge clk);
        chk(hit_ready == 1'b0, "R10", int'(hit_ready), 0);
        chk(int'(out_addr) == 40, "R10", int'(out_addr), 40);
        chk($countones(out_valid) == 1, "R10", int'(out_valid), 1);
        @(posedge clk); #1;
        out_ready = 4'hF;
        @(posedge clk); #1;
        hit_valid = 1'b0;
        expect_addrs("R10", 2, 40, 41, 0, 0);
    endtask

    task automatic t_mode_switch;
        nrec = 0;
        out_ready = 4'h0;
        send_hit(50, 3);
        trig_mode = 1'b1;
        hit_valid = 1'b1; hit_addr = 10'd51; hit_ts = 8'd4;
        cyc(2);
        @(negedge clk);
        chk(hit_ready == 1'b0, "R11", int'(hit_ready), 0);
        @(posedge clk); #1;
        out_ready = 4'hF;
        @(posedge clk); #1;
        hit_valid = 1'b0;
        cyc(3);
        send_hit(52, 5);
        expect_addrs("R11", 2, 50, 51, 0, 0);
        trig_mode = 1'b0; cyc(2);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        @(posedge clk); #1;
        t_counter();
        t_triggerless();
        t_window();
        t_lifetime();
        t_overflow();
        t_retire_collision();
        t_backpressure();
        t_mode_switch();
        finish_run();
    end
endmodule